// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Front End

This block is the receive side of a two-wire serial EEPROM. It runs on the system clock and oversamples the clock line and the data line. It finds bus START and STOP conditions and shifts in bytes on rising clock edges. It decides, byte by byte, whether to pull the data line low during the acknowledge clock. The first byte after a START is the control byte. Only its upper nibble is compared against a fixed device code. The three chip-select bits are ignored, and the lowest bit selects read or write.

In a write, the byte after the control byte is the word address. Every byte after that is a data byte. Each accepted item is handed to a write buffer through one-cycle strobes. `xfer_start_o` marks an accepted write control byte. `addr_load_o` marks a word address and `byte_valid_o` marks a data byte. `wr_commit_o` fires on a STOP that closes a transfer holding data, and the write engine uses it to begin its programming cycle. While the write engine reports busy, the block acknowledges nothing. A read control byte is acknowledged. Returning the read data belongs to another block.

Top module: `eeprom_bus_slave`

## Requirements
- R1: A START (data line falling while the clock line is high) opens a transfer. A STOP (data line rising while the clock line is high) closes it. Bytes clocked without a preceding START are never acknowledged.
- R2: If control byte bits 7..4 differ from the device code 1010b, that byte and every later byte up to the next START are left unacknowledged, and no strobe fires.
- R3: Control byte bits 3..1 have no effect: all eight combinations with a matching code are acknowledged identically.
- R4: The acknowledge drive (`ack_drive_o` high pulls the data line low) rises after the falling clock edge that ends the eighth bit. It falls after the falling edge of the ninth clock, and it is never asserted while a data bit is clocked high.
- R5: While `wr_busy_i` is high at the acknowledge decision, no byte of any kind is acknowledged, and no strobe fires for it.
- R6: An acknowledged control byte with bit 0 = 0 pulses `xfer_start_o` once. With bit 0 = 1 it is acknowledged without that pulse, and the following bytes are ignored until the next START.
- R7: The byte after an accepted write control byte is acknowledged, appears on `word_addr_o` and is flagged by a one-cycle `addr_load_o`.
- R8: Each later byte, received MSB first, is acknowledged, appears on `byte_data_o` and is flagged by a one-cycle `byte_valid_o`. Any number of bytes may follow in one transfer.
- R9: A STOP pulses `wr_commit_o` once when at least one data byte was accepted since the START. A STOP with no data byte gives no pulse.
- R10: A repeated START at any bit position drops the current byte and makes the next byte a control byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| wr_busy_i | input | 1 | Write engine busy; suppresses acknowledgement |
| ack_drive_o | output | 1 | High to pull the data line low |
| xfer_start_o | output | 1 | One-cycle strobe: write control byte accepted |
| addr_load_o | output | 1 | One-cycle strobe: word address valid |
| word_addr_o | output | 8 | Last accepted word address |
| byte_valid_o | output | 1 | One-cycle strobe: data byte valid |
| byte_data_o | output | 8 | Last accepted data byte |
| wr_commit_o | output | 1 | One-cycle strobe: STOP after data, begin programming |

## Verification
The bench sweeps all eight chip-select values with a matching code, so any dependence of matching on those bits shows up. It also sweeps all fifteen wrong codes, which separates a full-nibble compare from a partial one. A long page of arithmetic data values checks bit order and count over many consecutive bytes. Separate runs cover read direction, busy during the control byte and during a data byte, a STOP with no data, a repeated START in the middle of a byte, and stray clocking with no START. Between them these tell apart strobe gating, commit gating and the return to control-byte parsing.

// File: rtl/eeprom_bus_pkg.sv
package eeprom_bus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CTRL = 2'd1,
    PH_ADDR = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  // Upper nibble compare; chip-select bits are deliberately left out.
  function automatic logic ctrl_matches(input logic [7:0] ctrl, input logic [3:0] code);
    return ctrl[7:4] == code;
  endfunction

  function automatic logic ctrl_is_read(input logic [7:0] ctrl);
    return ctrl[0];
  endfunction

  // Phase entered once the acknowledge clock of an accepted byte ends.
  function automatic phase_e phase_after_ack(input phase_e cur, input logic rd);
    case (cur)
      PH_CTRL: return rd ? PH_IDLE : PH_ADDR;
      PH_ADDR: return PH_DATA;
      PH_DATA: return PH_DATA;
      default: return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;
  localparam int IDX_SCL = 1;
  localparam int IDX_SDA = 0;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw[g]),
      .q_o  (lvl[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end

  logic scl_hi_steady;
  assign scl_hi_steady = lvl[IDX_SCL] & prev[IDX_SCL];

  assign sda_lvl_o  = lvl[IDX_SDA];
  assign scl_rise_o = lvl[IDX_SCL] & ~prev[IDX_SCL];
  assign scl_fall_o = ~lvl[IDX_SCL] & prev[IDX_SCL];
  assign start_o    = scl_hi_steady & prev[IDX_SDA] & ~lvl[IDX_SDA];
  assign stop_o     = scl_hi_steady & ~prev[IDX_SDA] & lvl[IDX_SDA];
endmodule

// File: rtl/byte_rx.sv
module byte_rx #(
  parameter int W     = 8,
  parameter int CNT_W = $clog2(W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             scl_rise_i,
  input  logic             bit_i,
  output logic [W-1:0]     data_o,
  output logic             full_o,
  output logic             ack_clk_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(W + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      data_o <= '0;
    end else if (clear_i) begin
      cnt <= '0;
    end else if (run_i && scl_rise_i && cnt <= CNT_FULL) begin
      cnt <= cnt + 1'b1;
      if (cnt < CNT_FULL) data_o <= {data_o[W-2:0], bit_i};
    end
  end

  assign full_o    = (cnt == CNT_FULL);
  assign ack_clk_o = (cnt == CNT_ACK);
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
  import eeprom_bus_pkg::*;
#(
  parameter int         BYTE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wr_busy_i,
  output logic              ack_drive_o,
  output logic              xfer_start_o,
  output logic              addr_load_o,
  output logic [BYTE_W-1:0] word_addr_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              wr_commit_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);

  // Named internal events (also observed by the bound checker).
  logic sda_lvl, scl_rise_evt, scl_fall_evt, start_evt, stop_evt;
  logic rx_full, rx_ack_clk, rx_clear, rx_run;
  logic [BYTE_W-1:0] rx_byte;
  logic ack_decide_evt, ack_ok, ack_end_evt;

  phase_e phase_q, next_q;
  logic   got_data_q;

  bus_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl_o (sda_lvl),
    .scl_rise_o(scl_rise_evt),
    .scl_fall_o(scl_fall_evt),
    .start_o   (start_evt),
    .stop_o    (stop_evt)
  );

  byte_rx #(.W(BYTE_W), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (rx_clear),
    .run_i     (rx_run),
    .scl_rise_i(scl_rise_evt),
    .bit_i     (sda_lvl),
    .data_o    (rx_byte),
    .full_o    (rx_full),
    .ack_clk_o (rx_ack_clk)
  );

  assign rx_run         = (phase_q != PH_IDLE);
  assign ack_decide_evt = rx_run & scl_fall_evt & rx_full;
  assign ack_end_evt    = rx_run & scl_fall_evt & rx_ack_clk;
  assign ack_ok         = !wr_busy_i &&
                          (phase_q != PH_CTRL || ctrl_matches(rx_byte[BYTE_W-1 -: 8], DEV_CODE));
  assign rx_clear       = start_evt | stop_evt | ack_end_evt | (ack_decide_evt & ~ack_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      next_q       <= PH_IDLE;
      got_data_q   <= 1'b0;
      ack_drive_o  <= 1'b0;
      xfer_start_o <= 1'b0;
      addr_load_o  <= 1'b0;
      byte_valid_o <= 1'b0;
      wr_commit_o  <= 1'b0;
      word_addr_o  <= '0;
      byte_data_o  <= '0;
    end else begin
      xfer_start_o <= 1'b0;
      addr_load_o  <= 1'b0;
      byte_valid_o <= 1'b0;
      wr_commit_o  <= 1'b0;
      if (start_evt) begin
        phase_q     <= PH_CTRL;
        got_data_q  <= 1'b0;
        ack_drive_o <= 1'b0;
      end else if (stop_evt) begin
        wr_commit_o <= got_data_q;
        phase_q     <= PH_IDLE;
        got_data_q  <= 1'b0;
        ack_drive_o <= 1'b0;
      end else if (ack_decide_evt) begin
        if (ack_ok) begin
          ack_drive_o <= 1'b1;
          next_q      <= phase_after_ack(phase_q, ctrl_is_read(rx_byte[7:0]));
          case (phase_q)
            PH_CTRL: xfer_start_o <= !ctrl_is_read(rx_byte[7:0]);
            PH_ADDR: begin
              addr_load_o <= 1'b1;
              word_addr_o <= rx_byte;
            end
            PH_DATA: begin
              byte_valid_o <= 1'b1;
              byte_data_o  <= rx_byte;
              got_data_q   <= 1'b1;
            end
            default: ;
          endcase
        end else begin
          phase_q <= PH_IDLE;
        end
      end else if (ack_end_evt) begin
        ack_drive_o <= 1'b0;
        phase_q     <= next_q;
      end
    end
  end
endmodule

// File: rtl/eeprom_bus_slave_chk.sv
module eeprom_bus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_busy_i,
  input logic ack_drive_o,
  input logic scl_fall_evt,
  input logic start_evt,
  input logic stop_evt,
  input logic xfer_start_o,
  input logic addr_load_o,
  input logic byte_valid_o,
  input logic wr_commit_o
);
  AST_ACK_RISES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive_o) |-> $past(scl_fall_evt)); // R4
  AST_ACK_FALLS_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_drive_o) |-> $past(scl_fall_evt | start_evt | stop_evt)); // R4
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive_o) |-> !$past(wr_busy_i)); // R5
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !ack_drive_o); // R10
  AST_DATA_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> ack_drive_o); // R8
  AST_ADDR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load_o |-> ack_drive_o); // R7
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_evt)); // R9
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_start_o, addr_load_o, byte_valid_o, wr_commit_o})); // R6
endmodule

bind eeprom_bus_slave eeprom_bus_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_busy_i   (wr_busy_i),
  .ack_drive_o (ack_drive_o),
  .scl_fall_evt(scl_fall_evt),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .xfer_start_o(xfer_start_o),
  .addr_load_o (addr_load_o),
  .byte_valid_o(byte_valid_o),
  .wr_commit_o (wr_commit_o)
);

// File: tb/eeprom_bus_slave_tb.sv
module eeprom_bus_slave_tb;
  localparam int CLK_P = 10;
  localparam int Q     = 8;   // system clocks per quarter bus bit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_line;
  logic ack_drive, xfer_start, addr_load, byte_valid, wr_commit;
  logic [7:0] word_addr, byte_data;

  int n_checks = 0, n_fail = 0;
  int n_start = 0, n_addr = 0, n_data = 0, n_commit = 0;
  logic [7:0] last_addr = '0;
  logic [7:0] data_log [0:63];
  bit drive_in_bit = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  assign sda_line = sda_m & ~ack_drive;

  eeprom_bus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .wr_busy_i(busy),
    .ack_drive_o(ack_drive), .xfer_start_o(xfer_start), .addr_load_o(addr_load),
    .word_addr_o(word_addr), .byte_valid_o(byte_valid), .byte_data_o(byte_data),
    .wr_commit_o(wr_commit)
  );

  always @(negedge clk) begin
    if (xfer_start) n_start++;
    if (addr_load) begin n_addr++; last_addr = word_addr; end
    if (byte_valid) begin data_log[n_data % 64] = byte_data; n_data++; end
    if (wr_commit) n_commit++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
    if (ack_drive) drive_in_bit = 1'b1;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  // Eight bits MSB first plus the acknowledge clock; returns 1 when acknowledged.
  task automatic send_byte(input logic [7:0] b, output bit acked);
    drive_in_bit = 1'b0;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    check(!drive_in_bit, "R4 no drive in data bits", int'(drive_in_bit), 0);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q); scl_m = 1'b0; tick(Q);
    check(ack_drive == 1'b0, "R4 release after ninth clock", int'(ack_drive), 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    check(1'b0, "WATCHDOG", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    int s_start, s_addr, s_data, s_commit;
    tick(5); rst_n = 1'b1; tick(5);
    check(ack_drive == 1'b0, "R4 reset drive", int'(ack_drive), 0);
    check(n_start + n_addr + n_data + n_commit == 0, "R9 reset strobes",
          n_start + n_addr + n_data + n_commit, 0);

    // R3: every chip-select value with matching code
    for (int cs = 0; cs < 8; cs++) begin
      s_start = n_start; s_commit = n_commit;
      bus_start;
      send_byte({4'b1010, 3'(cs), 1'b0}, ack);
      check(ack, "R3 ctrl ack", int'(ack), 1);
      check(n_start == s_start + 1, "R6 start strobe", n_start, s_start + 1);
      send_byte(8'(cs * 8 + 3), ack);
      check(ack && last_addr == 8'(cs * 8 + 3), "R7 word address", int'(last_addr), cs * 8 + 3);
      send_byte(8'hC0 ^ 8'(cs), ack);
      check(ack && data_log[(n_data - 1) % 64] == (8'hC0 ^ 8'(cs)), "R8 data byte",
            int'(data_log[(n_data - 1) % 64]), int'(8'hC0 ^ 8'(cs)));
      bus_stop; tick(Q);
      check(n_commit == s_commit + 1, "R9 commit after data", n_commit, s_commit + 1);
    end

    // R2: every wrong device code
    for (int code = 0; code < 16; code++) begin
      if (code == 10) continue;
      s_start = n_start; s_addr = n_addr; s_commit = n_commit;
      bus_start;
      send_byte({4'(code), 3'b101, 1'b0}, ack);
      check(!ack, "R2 wrong code nack", int'(ack), 0);
      send_byte(8'h55, ack);
      check(!ack, "R2 following byte nack", int'(ack), 0);
      bus_stop; tick(Q);
      check(n_start == s_start && n_addr == s_addr && n_commit == s_commit, "R2 no strobes",
            n_start + n_addr + n_commit, s_start + s_addr + s_commit);
    end

    // R6: read direction
    s_start = n_start; s_addr = n_addr;
    bus_start;
    send_byte(8'b1010_0101, ack);
    check(ack, "R6 read ctrl ack", int'(ack), 1);
    check(n_start == s_start, "R6 no start strobe on read", n_start, s_start);
    send_byte(8'h22, ack);
    check(!ack && n_addr == s_addr, "R6 bytes ignored after read", n_addr, s_addr);
    bus_stop; tick(Q);

    // R8: long page with arithmetic data
    s_data = n_data; s_commit = n_commit;
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h40, ack);
    check(ack && last_addr == 8'h40, "R7 page address", int'(last_addr), 8'h40);
    for (int i = 0; i < 12; i++) begin
      send_byte(8'((i * 37 + 5) & 255), ack);
      check(ack, "R8 page ack", int'(ack), 1);
      check(data_log[(s_data + i) % 64] == 8'((i * 37 + 5) & 255), "R8 page data",
            int'(data_log[(s_data + i) % 64]), (i * 37 + 5) & 255);
    end
    check(n_data == s_data + 12, "R8 page count", n_data, s_data + 12);
    bus_stop; tick(Q);
    check(n_commit == s_commit + 1, "R9 page commit", n_commit, s_commit + 1);

    // R9: STOP without data
    s_commit = n_commit;
    bus_start;
    send_byte(8'hAE, ack);
    send_byte(8'h09, ack);
    bus_stop; tick(Q);
    check(n_commit == s_commit, "R9 no commit without data", n_commit, s_commit);

    // R5: busy at control byte and at data byte
    busy = 1'b1; s_start = n_start;
    bus_start;
    send_byte(8'hA0, ack);
    check(!ack && n_start == s_start, "R5 busy ctrl nack", int'(ack), 0);
    bus_stop; tick(Q);
    busy = 1'b0; s_data = n_data; s_commit = n_commit;
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h12, ack);
    check(ack, "R5 addr ack when idle", int'(ack), 1);
    busy = 1'b1;
    send_byte(8'h99, ack);
    check(!ack && n_data == s_data, "R5 busy data nack", n_data, s_data);
    bus_stop; tick(Q);
    check(n_commit == s_commit, "R5 no commit when refused", n_commit, s_commit);
    busy = 1'b0;

    // R1: clocking without START after a STOP
    scl_m = 1'b0; tick(Q);
    s_start = n_start;
    send_byte(8'hA0, ack);
    check(!ack && n_start == s_start, "R1 no START no ack", int'(ack), 0);

    // R10: repeated START in the middle of a data byte
    s_data = n_data;
    bus_start;
    send_byte(8'hA0, ack);
    send_byte(8'h11, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start;
    send_byte(8'hA2, ack);
    check(ack, "R10 ctrl after repeated START", int'(ack), 1);
    send_byte(8'h77, ack);
    check(ack && last_addr == 8'h77, "R10 new address", int'(last_addr), 8'h77);
    check(n_data == s_data, "R10 partial byte dropped", n_data, s_data);
    bus_stop; tick(Q);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule